// File: doc/BRIEF.md
# Fractional Clock-Enable Bank

This block turns one fast source clock into four independent streams of single-cycle enable pulses. Each stream has an average rate equal to the source rate multiplied by 18 and divided by a programmable divisor between 18 and 35. The output therefore runs at anywhere from about half of the source rate up to the full source rate. Logic downstream qualifies its registers with these enables and so works at a reduced effective rate without a second clock domain.

All four channels are controlled from a single 32-bit control word. Channel n owns byte n of that word, which holds a 6-bit divisor and a stop flag. Software can replace the whole word with one write. It can also use two write-only aliases that set or clear selected bits, so one channel can be changed without a read-modify-write. Each channel keeps a phase accumulator. While a channel is stopped, the accumulator is held at zero.

Top module: `frac_tick_bank`

## Requirements
- R1: After reset the control word reads 0x92929292: every stop flag is 1, every divisor field is 18, and no enable pulse is produced.
- R2: A write at offset 0x0 replaces the control word. A read at offset 0x0, 0x4 or 0x8 returns the control word as it stood before the clock edge, on `bus_rdata` after that edge. A read at any other offset returns zero.
- R3: A write at offset 0x4 sets every control bit that is 1 in the write data and leaves the other bits unchanged.
- R4: A write at offset 0x8 clears every control bit that is 1 in the write data and leaves the other bits unchanged.
- R5: A write to any offset other than 0x0, 0x4 or 0x8, or a cycle with the strobe low, leaves the control word unchanged.
- R6: Channel n uses bits 8n+7..8n. Bits 5..0 hold the divisor, bit 7 is the stop flag (1 = stopped), and bit 6 is stored and read back but has no effect on the output.
- R7: Once the stop flag of a channel is cleared at edge k, its enable is high after edge k+j exactly when floor(18j/F) > floor(18(j-1)/F), where F is the divisor. Over N cycles the channel therefore gives floor(18N/F) pulses.
- R8: A divisor field below 18 behaves as 18, and a field above 35 behaves as 35. A channel whose effective divisor is 18 pulses on every cycle.
- R9: A stopped channel produces no pulses. When it is released, its pulse pattern starts again from a zero accumulator.
- R10: A change of divisor on a running channel applies from the next source cycle and does not clear the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_rdata | output | 32 | Registered read data |
| tick_en | output | 4 | One enable pulse stream per channel |

## Verification
The assertions assume that the address, write data and strobe are known and stable at every clock edge once reset is released, and that each cycle carries at most one write. The bench changes these inputs only just after a rising edge and holds them for a whole cycle. It uses only defined values, and it drives unmapped offsets on purpose to cover the ignore case. The bench sweeps every 6-bit divisor value across all four lanes. It keeps a cycle-by-cycle model of each accumulator, so stopping a channel, releasing it and changing its divisor in flight are all predicted arithmetically.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;

  // Byte offsets of the three register views
  localparam int unsigned OFS_LOAD = 0;
  localparam int unsigned OFS_SET  = 4;
  localparam int unsigned OFS_CLR  = 8;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } wr_op_e;

endpackage

// File: rtl/frac_tick_regs.sv
module frac_tick_regs
  import frac_tick_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned RST_FRAC = 18
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_CH*LANE_W-1:0]   wdata,
  input  logic                       we,
  output logic [NUM_CH*LANE_W-1:0]   rdata,
  output logic [NUM_CH*LANE_W-1:0]   ctrl
);
  localparam int unsigned REG_W = NUM_CH * LANE_W;
  // stop flag set, divisor at its reset value
  localparam logic [LANE_W-1:0] RST_LANE =
    LANE_W'((1 << (LANE_W - 1)) | RST_FRAC);
  localparam logic [REG_W-1:0] RST_WORD = {NUM_CH{RST_LANE}};

  logic [REG_W-1:0] ctrl_q;
  logic             mapped;
  wr_op_e           op;

  always_comb begin
    mapped = (addr == ADDR_W'(OFS_LOAD)) || (addr == ADDR_W'(OFS_SET)) ||
             (addr == ADDR_W'(OFS_CLR));
    op = OP_NONE;
    if (we) begin
      if (addr == ADDR_W'(OFS_LOAD))     op = OP_LOAD;
      else if (addr == ADDR_W'(OFS_SET)) op = OP_SET;
      else if (addr == ADDR_W'(OFS_CLR)) op = OP_CLR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= RST_WORD;
      rdata  <= '0;
    end else begin
      unique case (op)
        OP_LOAD: ctrl_q <= wdata;
        OP_SET:  ctrl_q <= ctrl_q | wdata;
        OP_CLR:  ctrl_q <= ctrl_q & ~wdata;
        default: ctrl_q <= ctrl_q;
      endcase
      rdata <= mapped ? ctrl_q : '0;
    end
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/frac_tick_chan.sv
module frac_tick_chan #(
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned FRAC_W  = 6,
  parameter int unsigned NUMER   = 18,
  parameter int unsigned FRAC_LO = 18,
  parameter int unsigned FRAC_HI = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] lane,
  output logic              tick
);
  localparam int unsigned SUM_W    = FRAC_W + 1;
  localparam int unsigned STOP_BIT = LANE_W - 1;

  logic [SUM_W-1:0] field, eff, sum, acc_q;
  logic             stopped;

  always_comb begin
    stopped = lane[STOP_BIT];
    field   = {1'b0, lane[FRAC_W-1:0]};
    if (field < SUM_W'(FRAC_LO))      eff = SUM_W'(FRAC_LO);
    else if (field > SUM_W'(FRAC_HI)) eff = SUM_W'(FRAC_HI);
    else                              eff = field;
    sum = acc_q + SUM_W'(NUMER);
  end

  always_ff @(posedge clk) begin
    if (rst || stopped) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (sum >= eff) begin
      acc_q <= sum - eff;
      tick  <= 1'b1;
    end else begin
      acc_q <= sum;
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/frac_tick_bank.sv
module frac_tick_bank #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned FRAC_W   = 6,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUMER    = 18,
  parameter int unsigned FRAC_LO  = 18,
  parameter int unsigned FRAC_HI  = 35
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [NUM_CH*LANE_W-1:0] bus_wdata,
  input  logic                     bus_we,
  output logic [NUM_CH*LANE_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0]        tick_en
);
  localparam int unsigned REG_W = NUM_CH * LANE_W;

  logic [REG_W-1:0] ctrl_q;

  frac_tick_regs #(
    .NUM_CH(NUM_CH), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .RST_FRAC(FRAC_LO)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .rdata(bus_rdata), .ctrl(ctrl_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    frac_tick_chan #(
      .LANE_W(LANE_W), .FRAC_W(FRAC_W), .NUMER(NUMER),
      .FRAC_LO(FRAC_LO), .FRAC_HI(FRAC_HI)
    ) u_chan (
      .clk(clk), .rst(rst),
      .lane(ctrl_q[c*LANE_W +: LANE_W]),
      .tick(tick_en[c])
    );
  end

endmodule

// File: rtl/frac_tick_bank_chk.sv
module frac_tick_bank_chk
  import frac_tick_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned FRAC_W  = 6,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned FRAC_LO = 18
) (
  input logic                     clk,
  input logic                     rst,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [NUM_CH*LANE_W-1:0] bus_wdata,
  input logic                     bus_we,
  input logic [NUM_CH*LANE_W-1:0] ctrl_q,
  input logic [NUM_CH-1:0]        tick_en
);
  localparam logic [LANE_W-1:0] RST_LANE =
    LANE_W'((1 << (LANE_W - 1)) | FRAC_LO);

  logic wr_load, wr_set, wr_clr;
  assign wr_load = bus_we && (bus_addr == ADDR_W'(OFS_LOAD));
  assign wr_set  = bus_we && (bus_addr == ADDR_W'(OFS_SET));
  assign wr_clr  = bus_we && (bus_addr == ADDR_W'(OFS_CLR));

  // R1
  reset_word_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ctrl_q == {NUM_CH{RST_LANE}});

  // R2
  load_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_load |=> ctrl_q == $past(bus_wdata));

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> (ctrl_q & $past(bus_wdata)) == $past(bus_wdata));

  // R4
  clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> (ctrl_q & $past(bus_wdata)) == '0);

  // R5
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_load || wr_set || wr_clr) |=> $stable(ctrl_q));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R9
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl_q[c*LANE_W + LANE_W - 1] |=> !tick_en[c]);

    // R8
    min_divisor_full_rate_chk: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_q[c*LANE_W + LANE_W - 1] &&
       ctrl_q[c*LANE_W +: FRAC_W] <= FRAC_W'(FRAC_LO)) |=> tick_en[c]);
  end

endmodule

bind frac_tick_bank frac_tick_bank_chk #(
  .NUM_CH(NUM_CH), .LANE_W(LANE_W), .FRAC_W(FRAC_W),
  .ADDR_W(ADDR_W), .FRAC_LO(FRAC_LO)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .ctrl_q(ctrl_q), .tick_en(tick_en)
);

// File: tb/frac_tick_bank_bench.sv
`timescale 1ns/1ps
module frac_tick_bank_bench;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  tick;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] mirror;
  int          acc_m [NCH];
  int          tick_cnt [NCH];
  int          ph_err;
  string       ph_what;
  logic [31:0] ph_act, ph_exp;

  frac_tick_bank u_frac_tick_bank (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .tick_en(tick)
  );

  always #2 clk = ~clk;

  function automatic int eff_div(input logic [7:0] ln);
    int f;
    f = int'(ln[5:0]);
    if (f < 18) f = 18;
    if (f > 35) f = 35;
    return f;
  endfunction

  task automatic note_err(input string what, input logic [31:0] act,
                          input logic [31:0] exp);
    if (ph_err == 0) begin
      ph_what = what; ph_act = act; ph_exp = exp;
    end
    ph_err++;
  endtask

  // One source cycle: predict, drive, wait past the edge, compare
  task automatic step(input logic [3:0] a, input logic [31:0] d, input logic w);
    logic [3:0]  exp_t;
    logic [31:0] exp_r;
    for (int c = 0; c < NCH; c++) begin
      logic [7:0] ln;
      int f, s;
      ln = mirror[8*c +: 8];
      f  = eff_div(ln);
      if (ln[7]) begin
        acc_m[c] = 0; exp_t[c] = 1'b0;
      end else begin
        s = acc_m[c] + 18;
        if (s >= f) begin exp_t[c] = 1'b1; acc_m[c] = s - f; end
        else        begin exp_t[c] = 1'b0; acc_m[c] = s;     end
      end
    end
    exp_r = (a == 4'd0 || a == 4'd4 || a == 4'd8) ? mirror : 32'h0;
    if (w) begin
      case (a)
        4'd0: mirror = d;
        4'd4: mirror = mirror | d;
        4'd8: mirror = mirror & ~d;
        default: ;
      endcase
    end
    addr = a; wdata = d; we = w;
    @(posedge clk); #1;
    we = 1'b0;
    for (int c = 0; c < NCH; c++) tick_cnt[c] += int'(tick[c]);
    if (tick !== exp_t)  note_err("tick_en", {28'h0, tick}, {28'h0, exp_t});
    if (rdata !== exp_r) note_err("bus_rdata", rdata, exp_r);
  endtask

  task automatic begin_phase();
    ph_err = 0;
    for (int c = 0; c < NCH; c++) tick_cnt[c] = 0;
  endtask

  task automatic end_phase(input string req);
    n_chk++;
    if (ph_err != 0) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (%0d mismatching cycles)",
               req, ph_what, ph_act, ph_exp, ph_err);
    end
  endtask

  task automatic check_val(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(4'd0, 32'h0, 1'b0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    mirror = 32'h9292_9292;
    for (int c = 0; c < NCH; c++) acc_m[c] = 0;
    repeat (3) @(posedge clk);
    #1;
    check_val("R1", "tick_en in reset", {28'h0, tick}, 32'h0);
    rst = 1'b0;

    // R1: reset word and silence
    begin_phase();
    idle(4);
    end_phase("R1");
    check_val("R1", "reset word", rdata, 32'h9292_9292);

    // R2 / R6: full load, bit 6 stored, lanes 0 and 1 running
    begin_phase();
    step(4'd0, 32'hCAFE_5A13, 1'b1);
    idle(20);
    end_phase("R2");
    check_val("R6", "read back with bit 6", rdata, 32'hCAFE_5A13);
    step(4'd4, 32'h0, 1'b0);
    check_val("R2", "read via set offset", rdata, 32'hCAFE_5A13);
    step(4'd8, 32'h0, 1'b0);
    check_val("R2", "read via clear offset", rdata, 32'hCAFE_5A13);

    // R3: set alias
    begin_phase();
    step(4'd4, 32'h0001_0080, 1'b1);
    idle(6);
    end_phase("R3");
    check_val("R3", "word after set", rdata, 32'hCAFF_5A93);

    // R4: clear alias releases lane 3
    begin_phase();
    step(4'd8, 32'h8000_0001, 1'b1);
    idle(30);
    end_phase("R4");
    check_val("R4", "word after clear", rdata, 32'h4AFF_5A92);

    // R5: unmapped writes and reads
    begin_phase();
    step(4'd12, 32'hFFFF_FFFF, 1'b1);
    step(4'd2,  32'h0000_0000, 1'b1);
    step(4'd12, 32'h0, 1'b0);
    check_val("R5", "unmapped read", rdata, 32'h0);
    idle(5);
    end_phase("R5");
    check_val("R5", "word after ignored writes", rdata, 32'h4AFF_5A92);

    // R7 / R8: every divisor value on every lane
    for (int v = 0; v < 64; v++) begin
      logic [31:0] val;
      step(4'd4, 32'h8080_8080, 1'b1);
      step(4'd0, 32'h0, 1'b0);
      for (int c = 0; c < NCH; c++) val[8*c +: 8] = 8'((v + 16 * c) & 63);
      step(4'd0, val, 1'b1);
      begin_phase();
      idle(72);
      end_phase((v >= 18 && v <= 35) ? "R7" : "R8");
      for (int c = 0; c < NCH; c++) begin
        int f;
        f = eff_div(val[8*c +: 8]);
        check_val((f == int'(val[8*c +: 6])) ? "R7" : "R8", "pulse count",
                  32'(tick_cnt[c]), 32'((18 * 72) / f));
      end
    end

    // R10: divisor changes in flight
    step(4'd4, 32'h8080_8080, 1'b1);
    idle(2);
    begin_phase();
    step(4'd0, 32'h8080_8023, 1'b1);
    idle(7);
    step(4'd0, 32'h8080_8019, 1'b1);
    idle(10);
    step(4'd0, 32'h8080_801D, 1'b1);
    idle(12);
    end_phase("R10");

    // R9: stop and release one lane mid-run
    begin_phase();
    step(4'd0, 32'h1414_1414, 1'b1);
    idle(10);
    step(4'd4, 32'h0080_0000, 1'b1);
    for (int i = 0; i < 10; i++) begin
      step(4'd0, 32'h0, 1'b0);
      if (i > 0) check_val("R9", "stopped lane 2", {31'h0, tick[2]}, 32'h0);
    end
    step(4'd8, 32'h0080_0000, 1'b1);
    idle(15);
    end_phase("R9");

    finish_run();
  end

endmodule